// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Eliminator

This block receives an active-low composite sync bit that an analog slicer has already produced. It drives out a clean active-low horizontal pulse with a fixed width, one pulse per video line. The equalizing and serration pulses that arrive at half-line spacing during vertical blanking do not produce output pulses. Neither do extra pulses placed inside a line, such as copy-protection pulses. The block measures the spacing between accepted sync edges. After each accepted edge it refuses new triggers until three quarters of the last measured line period have gone by.

The same measured period drives two other functions. A high-definition flag goes low once lines shorter than a set cycle count have been seen on several consecutive lines. That flag also selects the width of the output pulse. When sync edges stop arriving, a timeout drops the block back to hunting and the output stays high. All timing is set by parameters counted in clock cycles.

A three-state controller runs the block:
- HUNT is the state after reset and after a loss. The first falling edge moves it to VERIFY (transition "first edge").
- VERIFY holds a reference edge. A following edge at a plausible spacing moves it to LOCKED and emits a pulse (transition "spacing confirmed"). An edge at an implausible spacing stays in VERIFY and becomes the new reference (transition "re-reference").
- LOCKED accepts edges that arrive after the hold-off (transition "line accepted"). It returns to HUNT when twice the stored period passes with no accepted edge (transition "sync timeout").

Top module: `hsync_regen`

## Requirements
- R1: After reset, hsync_n and hdef_n are both 1 and the controller is in HUNT.
- R2: An output pulse starts only from a falling edge of csync_n. hsync_n goes low on the rising clock edge that follows the edge that first samples csync_n low. In HUNT the first falling edge produces no pulse. A second falling edge spaced MIN_PERIOD to MAX_PERIOD cycles later (inclusive) enters LOCKED and produces a pulse.
- R3: Each output pulse lasts SD_WIDTH cycles when hdef_n was 1 at the triggering edge, and HD_WIDTH cycles when hdef_n was 0.
- R4: In LOCKED, a falling edge that arrives fewer than floor(3*P/4) cycles after the last accepted edge is ignored, where P is the stored period. This covers half-line pulses and extra pulses inside a line.
- R5: The cycle spacing of an accepted edge becomes the new P when it lies in the plausible range. Otherwise P keeps its old value. A later hold-off uses the updated P.
- R6: In LOCKED, when 2*P cycles pass after the last accepted edge with no accepted edge, the controller enters HUNT. hsync_n then stays 1 until lock is regained.
- R7: A measured spacing below HD_PERIOD cycles classifies a line as high definition. hdef_n (0 means high definition) changes only after HD_LINES consecutive measured lines of the opposite class.
- R8: In VERIFY, an edge whose spacing is outside the plausible range produces no pulse and becomes the new reference edge.
- R9: hdef_n keeps its value across a loss of sync and while hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, low during sync tips |
| hsync_n | output | 1 | Regenerated horizontal pulse, active low |
| hdef_n | output | 1 | High-definition flag, low when the line rate is high |

## Verification
Checks run on every cycle for these rules: output pulses start only from a detected input edge, pulse lengths are one of the two allowed widths, the output stays quiet while hunting or verifying, and the definition flag moves only in the cycle after a line measurement and never while hunting. Other behaviour depends on stored history, so only the bench scenarios can show it. This includes the hold-off removing half-line and in-line extra pulses, the hold-off following a changed period, the timeout followed by re-acquisition through an implausible spacing, and the four-line stability of the definition flag in both directions. A cycle-by-cycle behavioural model in the bench compares both outputs throughout all of these scenarios.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    typedef enum logic [1:0] {
        HS_HUNT   = 2'd0,
        HS_VERIFY = 2'd1,
        HS_LOCKED = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hsr_edge_detect.sv
// Input sampler; flags a high-to-low transition of the sync bit.
module hsr_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign fall_o = sh_q[STAGES-1] & ~sh_q[STAGES-2];
endmodule

// File: rtl/hsr_period_track.sv
// Cycle counter since the reference edge, stored line period, and derived limits.
module hsr_period_track #(
    parameter int CNT_W      = 12,
    parameter int MIN_PERIOD = 32,
    parameter int MAX_PERIOD = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] since_o,
    output logic [CNT_W-1:0] holdoff_o,
    output logic [CNT_W:0]   loss_lim_o,
    output logic             plausible_o
);
    localparam logic [CNT_W-1:0] SAT   = '1;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PERIOD);

    logic [CNT_W-1:0] since_q, period_q;
    logic [CNT_W+1:0] triple;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q  <= '0;
            period_q <= MAX_C;
        end else begin
            if (restart_i)          since_q <= CNT_W'(1);
            else if (since_q != SAT) since_q <= since_q + 1'b1;
            if (load_i)             period_q <= since_q;
        end
    end

    assign triple      = ({2'b00, period_q} << 1) + {2'b00, period_q};
    assign holdoff_o   = triple[CNT_W+1:2];
    assign loss_lim_o  = {period_q, 1'b0};
    assign since_o     = since_q;
    assign plausible_o = (since_q >= MIN_C) && (since_q <= MAX_C);
endmodule

// File: rtl/hsr_hd_classifier.sv
// Line-rate classifier with a consecutive-line agreement filter.
module hsr_hd_classifier #(
    parameter int CNT_W     = 12,
    parameter int HD_PERIOD = 200,
    parameter int HD_LINES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] since_i,
    output logic             hd_o
);
    localparam int SW = $clog2(HD_LINES + 1);
    localparam logic [SW-1:0]    LAST = SW'(HD_LINES - 1);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(HD_PERIOD);

    logic          hd_q;
    logic [SW-1:0] streak_q;
    logic          line_hd;

    assign line_hd = since_i < LIM;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q     <= 1'b0;
            streak_q <= '0;
        end else if (sample_i) begin
            if (line_hd == hd_q) begin
                streak_q <= '0;
            end else if (streak_q == LAST) begin
                hd_q     <= line_hd;
                streak_q <= '0;
            end else begin
                streak_q <= streak_q + 1'b1;
            end
        end
    end

    assign hd_o = hd_q;
endmodule

// File: rtl/hsr_pulse_gen.sv
// Fixed-width pulse timer; width chosen at start from the definition flag.
module hsr_pulse_gen #(
    parameter int SD_WIDTH = 40,
    parameter int HD_WIDTH = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic hd_i,
    output logic busy_o
);
    localparam int MAXW = (SD_WIDTH > HD_WIDTH) ? SD_WIDTH : HD_WIDTH;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] SD_C = CW'(SD_WIDTH);
    localparam logic [CW-1:0] HD_C = CW'(HD_WIDTH);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start_i)     cnt_q <= hd_i ? HD_C : SD_C;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = cnt_q != '0;
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MIN_PERIOD = 32,
    parameter int MAX_PERIOD = 1500,
    parameter int HD_PERIOD  = 200,
    parameter int SD_WIDTH   = 40,
    parameter int HD_WIDTH   = 14,
    parameter int HD_LINES   = 4,
    parameter int IN_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic hsync_n,
    output logic hdef_n
);
    hs_state_e        state_q, state_d;
    logic             fall, restart, measure, trigger;
    logic             plausible, busy, hd_active, past_hold, timed_out;
    logic [CNT_W-1:0] since, holdoff;
    logic [CNT_W:0]   loss_lim;

    hsr_edge_detect #(.STAGES(IN_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(csync_n), .fall_o(fall)
    );

    hsr_period_track #(
        .CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)
    ) u_period (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .load_i(measure),
        .since_o(since), .holdoff_o(holdoff), .loss_lim_o(loss_lim),
        .plausible_o(plausible)
    );

    hsr_hd_classifier #(
        .CNT_W(CNT_W), .HD_PERIOD(HD_PERIOD), .HD_LINES(HD_LINES)
    ) u_class (
        .clk(clk), .rst_n(rst_n), .sample_i(measure), .since_i(since),
        .hd_o(hd_active)
    );

    hsr_pulse_gen #(.SD_WIDTH(SD_WIDTH), .HD_WIDTH(HD_WIDTH)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start_i(trigger), .hd_i(hd_active),
        .busy_o(busy)
    );

    assign past_hold = since >= holdoff;
    assign timed_out = {1'b0, since} >= loss_lim;

    // Next-state and control decode
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        measure = 1'b0;
        trigger = 1'b0;
        unique case (state_q)
            HS_HUNT: begin
                if (fall) begin
                    state_d = HS_VERIFY;
                    restart = 1'b1;
                end
            end
            HS_VERIFY: begin
                if (fall) begin
                    restart = 1'b1;
                    if (plausible) begin
                        state_d = HS_LOCKED;
                        measure = 1'b1;
                        trigger = 1'b1;
                    end
                end
            end
            HS_LOCKED: begin
                if (fall && past_hold) begin
                    restart = 1'b1;
                    trigger = 1'b1;
                    measure = plausible;
                end else if (timed_out) begin
                    state_d = HS_HUNT;
                end
            end
            default: state_d = HS_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_HUNT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            HS_LOCKED: hsync_n = ~busy;
            default:   hsync_n = 1'b1;
        endcase
    end

    assign hdef_n = ~hd_active;
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker
    import hsr_pkg::*;
#(
    parameter int SD_WIDTH = 40,
    parameter int HD_WIDTH = 14
) (
    input logic      clk,
    input logic      rst_n,
    input hs_state_e state,
    input logic      fall,
    input logic      measure,
    input logic      hsync_n,
    input logic      hdef_n
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run <= '0;
        else if (!hsync_n) low_run <= low_run + 1'b1;
        else               low_run <= '0;
    end

    // R2
    trig_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> $past(fall));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (low_run == 16'(SD_WIDTH) || low_run == 16'(HD_WIDTH)));

    // R6
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_HUNT) |=> hsync_n);

    // R8
    verify_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_VERIFY) |-> hsync_n);

    // R7
    hd_on_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hdef_n) |-> $past(measure));

    // R9
    hd_hold_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_HUNT && $past(state) == HS_HUNT) |-> $stable(hdef_n));
endmodule

bind hsync_regen hsr_checker #(.SD_WIDTH(SD_WIDTH), .HD_WIDTH(HD_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .fall(fall), .measure(measure),
    .hsync_n(hsync_n), .hdef_n(hdef_n)
);

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
    localparam int MINP = 32, MAXP = 1500, HDP = 200, SDW = 40, HDW = 14, HDL = 4;
    localparam int SAT = 4095;

    logic clk = 1'b0, rst_n = 1'b0, csync_n = 1'b1;
    logic hsync_n, hdef_n;
    int n_tests = 0, n_fail = 0;
    int pulses = 0, run = 0, last_width = 0;
    logic prev_h = 1'b1;

    // behavioural reference model state
    int m_state = 0, m_since = 0, m_per = MAXP, m_cnt = 0, m_streak = 0;
    bit m_hd = 0, m_s1 = 1, m_s2 = 1;

    hsync_regen dut (.clk(clk), .rst_n(rst_n), .csync_n(csync_n),
                     .hsync_n(hsync_n), .hdef_n(hdef_n));

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit in_range(input int s);
        return (s >= MINP) && (s <= MAXP);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_since = 0; m_per = MAXP; m_cnt = 0; m_streak = 0;
            m_hd = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            bit edge_seen, fire, meas, rs, old_hd;
            edge_seen = m_s2 && !m_s1;
            fire = 0; meas = 0; rs = 0; old_hd = m_hd;
            if (m_state == 0) begin
                if (edge_seen) begin m_state = 1; rs = 1; end
            end else if (m_state == 1) begin
                if (edge_seen) begin
                    rs = 1;
                    if (in_range(m_since)) begin m_state = 2; meas = 1; fire = 1; end
                end
            end else begin
                if (edge_seen && m_since >= (m_per * 3) / 4) begin
                    rs = 1; fire = 1; meas = in_range(m_since);
                end else if (m_since >= 2 * m_per) m_state = 0;
            end
            if (meas) begin
                if ((m_since < HDP) == m_hd) m_streak = 0;
                else if (m_streak == HDL - 1) begin m_hd = (m_since < HDP); m_streak = 0; end
                else m_streak++;
                m_per = m_since;
            end
            if (fire) m_cnt = old_hd ? HDW : SDW;
            else if (m_cnt > 0) m_cnt--;
            if (rs) m_since = 1;
            else if (m_since < SAT) m_since++;
            m_s2 = m_s1; m_s1 = csync_n;
        end
    end

    // per-cycle comparison and pulse bookkeeping, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_h;
            exp_h = !(m_state == 2 && m_cnt > 0);
            check(hsync_n == exp_h, "R2/R3/R4/R6 model hsync_n", int'(hsync_n), int'(exp_h));
            check(hdef_n == !m_hd, "R7/R9 model hdef_n", int'(hdef_n), int'(!m_hd));
            if (prev_h && !hsync_n) pulses++;
            if (!hsync_n) run++;
            else if (run > 0) begin last_width = run; run = 0; end
            prev_h = hsync_n;
        end
    end

    task automatic line(input int spacing, input int lowlen);
        for (int i = 0; i < spacing; i++) begin
            @(negedge clk);
            csync_n = (i < lowlen) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic cp_line();
        for (int i = 0; i < 640; i++) begin
            @(negedge clk);
            csync_n = (i < 20 || (i >= 100 && i < 106) || (i >= 150 && i < 156)) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csync_n = 1'b1;
        end
    endtask

    initial begin
        int c;
        repeat (5) @(negedge clk);
        check(hsync_n == 1'b1, "R1 reset hsync_n", int'(hsync_n), 1);
        check(hdef_n == 1'b1, "R1 reset hdef_n", int'(hdef_n), 1);
        rst_n = 1'b1;
        idle(10);
        check(hsync_n == 1'b1, "R1 idle after reset", int'(hsync_n), 1);

        // R2: acquisition
        c = pulses;
        line(640, 20);
        check(pulses == c, "R2 first edge gives no pulse", pulses, c);
        line(640, 20);
        check(pulses == c + 1, "R2 second edge locks", pulses, c + 1);
        check(last_width == SDW, "R3 SD width", last_width, SDW);
        repeat (4) line(640, 20);
        check(pulses == c + 5, "R2 one pulse per line", pulses, c + 5);

        // R4: half-line pulses and in-line extra pulses
        c = pulses;
        repeat (6) line(320, 20);
        check(pulses == c + 3, "R4 half lines removed", pulses, c + 3);
        c = pulses;
        repeat (3) cp_line();
        check(pulses == c + 3, "R4 in-line pulses ignored", pulses, c + 3);

        // R5: period follows the input, hold-off follows the period
        repeat (4) line(700, 20);
        c = pulses;
        line(500, 20);
        check(pulses == c + 1, "R5 edge at 700 accepted", pulses, c + 1);
        line(700, 20);
        check(pulses == c + 1, "R5 edge at 500 inside new hold-off", pulses, c + 1);

        // R6: timeout then re-acquire, R8: implausible spacing in verify
        idle(3000);
        check(hsync_n == 1'b1, "R6 output high after loss", int'(hsync_n), 1);
        c = pulses;
        line(2000, 20);
        check(pulses == c, "R6 hunting after loss", pulses, c);
        line(640, 20);
        check(pulses == c, "R8 implausible spacing no pulse", pulses, c);
        line(640, 20);
        check(pulses == c + 1, "R2 re-lock after new reference", pulses, c + 1);

        // R7: high-definition classification
        idle(2000);
        repeat (4) line(128, 8);
        check(hdef_n == 1'b1, "R7 three HD lines not enough", int'(hdef_n), 1);
        line(128, 8);
        check(hdef_n == 1'b0, "R7 fourth HD line flips flag", int'(hdef_n), 0);
        repeat (2) line(128, 8);
        check(last_width == HDW, "R3 HD width", last_width, HDW);

        // R9: flag survives loss; R7 back to SD
        idle(1000);
        check(hdef_n == 1'b0, "R9 flag kept across loss", int'(hdef_n), 0);
        repeat (2) line(640, 20);
        check(last_width == HDW, "R3 width follows current flag", last_width, HDW);
        repeat (2) line(640, 20);
        check(hdef_n == 1'b0, "R7 three SD lines not enough", int'(hdef_n), 0);
        line(640, 20);
        check(hdef_n == 1'b1, "R7 fourth SD line clears flag", int'(hdef_n), 1);
        line(640, 20);
        check(last_width == SDW, "R3 SD width restored", last_width, SDW);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule